// File: doc/BRIEF.md
# HDLC Receive Message Buffer

This block stores frames from a bit-level HDLC deframer so that a polling processor can collect them. The deframer does its own flag and abort detection, bit destuffing and CRC checking. It reports its results as single-cycle events: an opening flag, a received byte, a good close, an abort or a CRC/format error. All entries go into one ring of `DEPTH` locations, and a tag bit marks each entry as either a status word or a data byte.

For each frame, one status location is reserved when the frame opens. The data bytes are stored behind it. When the frame ends, the status word is written back into the reserved location, so the processor reads each frame's status ahead of its data. The buffer drives five indicators: frame active, head-is-status, empty, near-full and full. The processor reads through a show-ahead port with a one-entry pop strobe.

A programmable near-full level lets the processor drain long frames early. When a frame reaches that level, its status is closed as a partial end-of-message. When the buffer is full, the frame being received is cut off and reported with a zero byte count. In unformatted mode, bytes are stored as plain data entries and the frame events are ignored.

Top module: `hrx_msg_fifo`

## Requirements
- R1: The buffer holds `DEPTH` (default 64) tagged entries. `st_empty` is 1 exactly when no entry is stored, and `st_full` is 1 exactly when all `DEPTH` are stored. After reset the buffer is empty.
- R2: In HDLC mode, `ev_start` while no frame is active reserves one status entry at the tail. While its frame is open, that entry is not readable when it reaches the head: `rd_data` is 0, `st_next_status` is 0 and `rd_en` pops nothing.
- R3: A status entry has tag 1. Bits [7:6] give the end type (00 good, 01 abort, 10 error, 11 partial), and bits [5:0] give the number of data bytes that follow it, modulo 64. Data entries have tag 0 and carry the received byte. `ev_good`, `ev_error` and `ev_abort` write the final status into the reserved entry in place, so the status is read before that frame's data.
- R4: In HDLC mode, `st_in_msg` rises on the cycle after `ev_start` and falls on the cycle after a good, abort or error event. In unformatted mode (`cfg_hdlc`=0), `st_in_msg` is 1, every `ev_byte` is stored as a data entry while space remains, and frame events have no effect.
- R5: `st_next_status` is 1 exactly when the head entry is readable and tagged as status. `rd_data` shows the head entry's byte whenever the head is readable.
- R6: An abort before any data byte has been stored in the open status entry frees that entry, and the entry count drops by one.
- R7: `st_near` is 1 when `cfg_near_thr` is non-zero and the stored count is at least `cfg_near_thr`. A threshold of 0 keeps `st_near` at 0.
- R8: When a stored data byte raises the count from below a non-zero `cfg_near_thr` to or above it, the open status entry becomes 11 with the byte count including that byte, and it becomes readable. The next byte of the same frame first reserves a new status entry and then stores the byte (two entries). An end event with no new entry open writes nothing.
- R9: A data byte that arrives while the buffer is full and a status entry is open sets that status to 0xC0 (partial, count 0). The rest of the frame is dropped until its end event. Entries already stored stay readable.
- R10: `rd_en` pops at most one readable entry per cycle. A read on an empty buffer returns 0 and changes nothing. A pop and a push in the same cycle both take effect.
- R11: A frame whose opening arrives while the buffer is full stores nothing, including its end, but `st_in_msg` still follows the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_hdlc | input | 1 | 1 = HDLC frame mode, 0 = unformatted byte mode |
| cfg_near_thr | input | 6 | Near-full level; 0 disables |
| ev_start | input | 1 | Opening flag seen |
| ev_byte | input | 1 | Received byte valid |
| ev_data | input | 8 | Received byte |
| ev_good | input | 1 | Frame closed with good CRC |
| ev_abort | input | 1 | Frame aborted |
| ev_error | input | 1 | Frame closed with CRC or format error |
| rd_en | input | 1 | Pop the head entry |
| rd_data | output | 8 | Head entry byte, 0 when the head is not readable |
| st_in_msg | output | 1 | Frame active (always 1 in unformatted mode) |
| st_next_status | output | 1 | Head entry is a status word |
| st_empty | output | 1 | No entries stored |
| st_near | output | 1 | Count at or above the near-full level |
| st_full | output | 1 | All entries stored |

## Verification
The assertions assume that the deframer raises at most one of `ev_start`, `ev_byte`, `ev_good`, `ev_abort` and `ev_error` per cycle. They also assume that it sends `ev_start` only when no frame is active and that `cfg_hdlc` does not change while a frame is open. The bench meets these assumptions by tracking the open frame itself, choosing a single event per cycle, and switching mode only after a frame has ended and the buffer has drained. `cfg_near_thr` is changed only between frames, so each frame sees a single threshold crossing rule.

// File: rtl/hrx_pkg.sv
`timescale 1ns/1ps
package hrx_pkg;
   typedef enum logic [1:0] {
      END_GOOD  = 2'b00,
      END_ABORT = 2'b01,
      END_ERROR = 2'b10,
      END_PART  = 2'b11
   } hrx_end_e;
endpackage

// File: rtl/hrx_store.sv
`timescale 1ns/1ps
module hrx_store #(
   parameter int DW        = 8,
   parameter int DEPTH     = 64,
   parameter bit RST_STORE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       we_a,
   input  logic [$clog2(DEPTH)-1:0]   addr_a,
   input  logic [DW:0]                din_a,
   input  logic                       we_b,
   input  logic [$clog2(DEPTH)-1:0]   addr_b,
   input  logic [DW:0]                din_b,
   input  logic                       we_s,
   input  logic [$clog2(DEPTH)-1:0]   addr_s,
   input  logic [DW:0]                din_s,
   input  logic [$clog2(DEPTH)-1:0]   raddr,
   output logic [DW:0]                rq
);
   localparam int AW = $clog2(DEPTH);
   localparam int EW = DW + 1;

   logic [EW-1:0] ent [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [EW-1:0] ent_q;
      logic [EW-1:0] ent_d;
      logic          ent_we;
      always_comb begin
         ent_we = 1'b1;
         if (we_s && addr_s == AW'(i))      ent_d = din_s;
         else if (we_b && addr_b == AW'(i)) ent_d = din_b;
         else if (we_a && addr_a == AW'(i)) ent_d = din_a;
         else begin
            ent_d  = ent_q;
            ent_we = 1'b0;
         end
      end
      if (RST_STORE) begin : g_rst
         always_ff @(posedge clk) begin
            if (!rst_n)      ent_q <= '0;
            else if (ent_we) ent_q <= ent_d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            if (ent_we) ent_q <= ent_d;
         end
      end
      assign ent[i] = ent_q;
   end

   assign rq = ent[raddr];
endmodule

// File: rtl/hrx_ctrl.sv
`timescale 1ns/1ps
module hrx_ctrl
   import hrx_pkg::*;
#(
   parameter int DW    = 8,
   parameter int DEPTH = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_hdlc,
   input  logic [$clog2(DEPTH)-1:0]   cfg_near_thr,
   input  logic                       ev_start,
   input  logic                       ev_byte,
   input  logic [DW-1:0]              ev_data,
   input  logic                       ev_good,
   input  logic                       ev_abort,
   input  logic                       ev_error,
   input  logic                       rd_en,
   output logic                       we_a,
   output logic [$clog2(DEPTH)-1:0]   addr_a,
   output logic [DW:0]                din_a,
   output logic                       we_b,
   output logic [$clog2(DEPTH)-1:0]   addr_b,
   output logic [DW:0]                din_b,
   output logic                       we_s,
   output logic [$clog2(DEPTH)-1:0]   addr_s,
   output logic [DW:0]                din_s,
   output logic [$clog2(DEPTH)-1:0]   rptr,
   output logic [$clog2(DEPTH):0]     level,
   output logic                       head_ok,
   output logic                       in_msg
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;
   localparam int NW = DW - 2;
   localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
   localparam logic [DW:0]   SLOT_INIT = {1'b1, END_PART, {NW{1'b0}}};

   logic [CW-1:0] count_q, count_n;
   logic [AW-1:0] wptr_q, wptr_n, rptr_q, spos_q, spos_n;
   logic          sopen_q, sopen_n, inmsg_q, inmsg_n, disc_q, disc_n;
   logic [NW-1:0] bcnt_q, bcnt_n;
   logic [1:0]    push_n;
   logic          pop, rel, cross_ok;
   logic [CW-1:0] thr_w;
   hrx_end_e      end_code;

   assign thr_w    = {1'b0, cfg_near_thr};
   assign end_code = ev_abort ? END_ABORT : (ev_error ? END_ERROR : END_GOOD);
   assign addr_a   = wptr_q;
   assign addr_b   = wptr_q + AW'(1);

   always_comb begin
      head_ok  = (count_q != '0) && !(sopen_q && (rptr_q == spos_q));
      pop      = rd_en && head_ok;
      push_n   = 2'd0;
      rel      = 1'b0;
      cross_ok = 1'b0;
      we_a     = 1'b0;
      we_b     = 1'b0;
      we_s     = 1'b0;
      din_a    = '0;
      din_b    = {1'b0, ev_data};
      din_s    = '0;
      addr_s   = spos_q;
      inmsg_n  = inmsg_q;
      sopen_n  = sopen_q;
      spos_n   = spos_q;
      disc_n   = disc_q;
      bcnt_n   = bcnt_q;

      if (!cfg_hdlc) begin
         if (ev_byte && count_q != FULL_LVL) begin
            we_a   = 1'b1;
            din_a  = {1'b0, ev_data};
            push_n = 2'd1;
         end
      end else if (!inmsg_q) begin
         if (ev_start) begin
            inmsg_n = 1'b1;
            bcnt_n  = '0;
            if (count_q != FULL_LVL) begin
               we_a    = 1'b1;
               din_a   = SLOT_INIT;
               push_n  = 2'd1;
               spos_n  = wptr_q;
               sopen_n = 1'b1;
               disc_n  = 1'b0;
            end else begin
               disc_n  = 1'b1;
            end
         end
      end else if (ev_byte) begin
         if (disc_q) begin
            disc_n = 1'b1;
         end else if (sopen_q) begin
            if (count_q == FULL_LVL) begin
               we_s    = 1'b1;
               din_s   = SLOT_INIT;
               sopen_n = 1'b0;
               disc_n  = 1'b1;
            end else begin
               we_a     = 1'b1;
               din_a    = {1'b0, ev_data};
               push_n   = 2'd1;
               bcnt_n   = bcnt_q + NW'(1);
               cross_ok = 1'b1;
            end
         end else begin
            if (count_q <= FULL_LVL - CW'(2)) begin
               we_a     = 1'b1;
               din_a    = SLOT_INIT;
               we_b     = 1'b1;
               push_n   = 2'd2;
               spos_n   = wptr_q;
               sopen_n  = 1'b1;
               bcnt_n   = NW'(1);
               cross_ok = 1'b1;
            end else begin
               disc_n = 1'b1;
            end
         end
      end else if (ev_good || ev_abort || ev_error) begin
         inmsg_n = 1'b0;
         disc_n  = 1'b0;
         sopen_n = 1'b0;
         if (sopen_q) begin
            if (ev_abort && bcnt_q == '0) begin
               rel = 1'b1;
            end else begin
               we_s  = 1'b1;
               din_s = {1'b1, end_code, bcnt_q};
            end
         end
      end

      count_n = count_q + CW'(push_n) - CW'(pop) - CW'(rel);
      wptr_n  = wptr_q + AW'(push_n) - AW'(rel);

      if (cross_ok && thr_w != '0 && count_q < thr_w && count_n >= thr_w) begin
         we_s    = 1'b1;
         addr_s  = spos_n;
         din_s   = {1'b1, END_PART, bcnt_n};
         sopen_n = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         wptr_q  <= '0;
         rptr_q  <= '0;
         spos_q  <= '0;
         sopen_q <= 1'b0;
         inmsg_q <= 1'b0;
         disc_q  <= 1'b0;
         bcnt_q  <= '0;
      end else begin
         count_q <= count_n;
         wptr_q  <= wptr_n;
         rptr_q  <= rptr_q + AW'(pop);
         spos_q  <= spos_n;
         sopen_q <= sopen_n;
         inmsg_q <= inmsg_n;
         disc_q  <= disc_n;
         bcnt_q  <= bcnt_n;
      end
   end

   assign rptr   = rptr_q;
   assign level  = count_q;
   assign in_msg = inmsg_q;
endmodule

// File: rtl/hrx_msg_fifo.sv
`timescale 1ns/1ps
module hrx_msg_fifo #(
   parameter int DW        = 8,
   parameter int DEPTH     = 64,
   parameter bit RST_STORE = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       cfg_hdlc,
   input  logic [$clog2(DEPTH)-1:0]   cfg_near_thr,
   input  logic                       ev_start,
   input  logic                       ev_byte,
   input  logic [DW-1:0]              ev_data,
   input  logic                       ev_good,
   input  logic                       ev_abort,
   input  logic                       ev_error,
   input  logic                       rd_en,
   output logic [DW-1:0]              rd_data,
   output logic                       st_in_msg,
   output logic                       st_next_status,
   output logic                       st_empty,
   output logic                       st_near,
   output logic                       st_full
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = AW + 1;

   if (DEPTH < 4 || DEPTH != (1 << AW)) begin : g_bad_depth
      $error("hrx_msg_fifo: DEPTH must be a power of two, at least 4");
   end
   if (DW < 3) begin : g_bad_width
      $error("hrx_msg_fifo: DW must leave room for end type and count");
   end

   logic          we_a, we_b, we_s, head_ok, in_msg;
   logic [AW-1:0] addr_a, addr_b, addr_s, rptr;
   logic [DW:0]   din_a, din_b, din_s, head;
   logic [CW-1:0] level;

   hrx_ctrl #(.DW(DW), .DEPTH(DEPTH)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .cfg_hdlc(cfg_hdlc), .cfg_near_thr(cfg_near_thr),
      .ev_start(ev_start), .ev_byte(ev_byte), .ev_data(ev_data),
      .ev_good(ev_good), .ev_abort(ev_abort), .ev_error(ev_error), .rd_en(rd_en),
      .we_a(we_a), .addr_a(addr_a), .din_a(din_a),
      .we_b(we_b), .addr_b(addr_b), .din_b(din_b),
      .we_s(we_s), .addr_s(addr_s), .din_s(din_s),
      .rptr(rptr), .level(level), .head_ok(head_ok), .in_msg(in_msg)
   );

   hrx_store #(.DW(DW), .DEPTH(DEPTH), .RST_STORE(RST_STORE)) u_store (
      .clk(clk), .rst_n(rst_n),
      .we_a(we_a), .addr_a(addr_a), .din_a(din_a),
      .we_b(we_b), .addr_b(addr_b), .din_b(din_b),
      .we_s(we_s), .addr_s(addr_s), .din_s(din_s),
      .raddr(rptr), .rq(head)
   );

   assign rd_data        = head_ok ? head[DW-1:0] : '0;
   assign st_next_status = head_ok && head[DW];
   assign st_empty       = (level == '0);
   assign st_full        = (level == CW'(DEPTH));
   assign st_near        = (cfg_near_thr != '0) && (level >= {1'b0, cfg_near_thr});
   assign st_in_msg      = cfg_hdlc ? in_msg : 1'b1;
endmodule

// File: rtl/hrx_msg_fifo_chk.sv
`timescale 1ns/1ps
module hrx_msg_fifo_chk #(
   parameter int DW    = 8,
   parameter int DEPTH = 64
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       cfg_hdlc,
   input logic [$clog2(DEPTH)-1:0]   cfg_near_thr,
   input logic                       ev_start,
   input logic                       ev_byte,
   input logic [DW-1:0]              ev_data,
   input logic                       ev_good,
   input logic                       ev_abort,
   input logic                       ev_error,
   input logic                       rd_en,
   input logic [DW-1:0]              rd_data,
   input logic                       st_in_msg,
   input logic                       st_next_status,
   input logic                       st_empty,
   input logic                       st_near,
   input logic                       st_full
);
   logic unused_data;
   assign unused_data = ^ev_data;

   AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      st_empty |-> (!st_next_status && rd_data == '0)); // R10
   AST_STATUS_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      st_next_status |-> !st_empty); // R5
   AST_UNFMT_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_hdlc |-> st_in_msg); // R4
   AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hdlc && ev_start) |=> (st_in_msg || !cfg_hdlc)); // R4
   AST_END_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_hdlc && (ev_abort || ev_good || ev_error)) |=> (!st_in_msg || !cfg_hdlc)); // R4
   AST_FULL_NEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (st_full && cfg_near_thr != '0) |-> st_near); // R7
   AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (st_full && !rd_en && !ev_abort) |=> st_full); // R9
   AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_empty && !ev_start && !ev_byte) |=> st_empty); // R10
endmodule

bind hrx_msg_fifo hrx_msg_fifo_chk #(.DW(DW), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/hrx_msg_fifo_tb.sv
`timescale 1ns/1ps
module hrx_msg_fifo_tb;
   localparam int DEPTH = 64;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_hdlc = 1'b1;
   logic [5:0] cfg_near_thr = '0;
   logic       ev_start = 0, ev_byte = 0, ev_good = 0, ev_abort = 0, ev_error = 0, rd_en = 0;
   logic [7:0] ev_data = '0;
   logic [7:0] rd_data;
   logic       st_in_msg, st_next_status, st_empty, st_near, st_full;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   hrx_msg_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_hdlc(cfg_hdlc), .cfg_near_thr(cfg_near_thr),
      .ev_start(ev_start), .ev_byte(ev_byte), .ev_data(ev_data),
      .ev_good(ev_good), .ev_abort(ev_abort), .ev_error(ev_error), .rd_en(rd_en),
      .rd_data(rd_data), .st_in_msg(st_in_msg), .st_next_status(st_next_status),
      .st_empty(st_empty), .st_near(st_near), .st_full(st_full)
   );

   task automatic chk(string req, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // reference model: queue of tagged entries, bit 8 = status tag
   logic [8:0] q[$];
   int  oidx = -1;
   bit  m_in = 0, m_disc = 0;
   int  m_bcnt = 0;

   always @(posedge clk) begin
      int L, npush, wi, nL, no, code;
      bit hk, pp, rel, cr;
      logic [8:0] p0, p1, wv;
      if (!rst_n) begin
         q.delete(); oidx = -1; m_in = 0; m_disc = 0; m_bcnt = 0;
      end else begin
         L = q.size(); hk = (L > 0) && (oidx != 0); pp = rd_en && hk;
         npush = 0; wi = -1; wv = 0; rel = 0; cr = 0; no = oidx; p0 = 0; p1 = 0;
         if (!cfg_hdlc) begin
            if (ev_byte && L < DEPTH) begin npush = 1; p0 = {1'b0, ev_data}; end
         end else if (!m_in) begin
            if (ev_start) begin
               m_in = 1; m_bcnt = 0;
               if (L < DEPTH) begin npush = 1; p0 = 9'h1C0; no = L; m_disc = 0; end
               else m_disc = 1;
            end
         end else if (ev_byte) begin
            if (m_disc) begin end
            else if (oidx >= 0) begin
               if (L == DEPTH) begin wi = oidx; wv = 9'h1C0; no = -1; m_disc = 1; end
               else begin npush = 1; p0 = {1'b0, ev_data}; m_bcnt = (m_bcnt + 1) % 64; cr = 1; end
            end else begin
               if (L <= DEPTH - 2) begin
                  npush = 2; p0 = 9'h1C0; p1 = {1'b0, ev_data}; no = L; m_bcnt = 1; cr = 1;
               end else m_disc = 1;
            end
         end else if (ev_good || ev_abort || ev_error) begin
            code = ev_abort ? 1 : (ev_error ? 2 : 0);
            if (oidx >= 0) begin
               if (ev_abort && m_bcnt == 0) rel = 1;
               else begin wi = oidx; wv = 9'(256 + code * 64 + m_bcnt); end
            end
            no = -1; m_in = 0; m_disc = 0;
         end
         nL = L + npush - int'(pp) - int'(rel);
         if (cr && cfg_near_thr != 0 && L < int'(cfg_near_thr) && nL >= int'(cfg_near_thr)) begin
            if (npush == 2) p0 = 9'(9'h1C0 + m_bcnt);
            else q[oidx] = 9'(9'h1C0 + m_bcnt);
            no = -1;
         end
         if (wi >= 0) q[wi] = wv;
         if (rel) void'(q.pop_back());
         if (npush >= 1) q.push_back(p0);
         if (npush == 2) q.push_back(p1);
         if (pp) begin void'(q.pop_front()); if (no >= 0) no--; end
         oidx = no;
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      int sz; bit hk;
      if (rst_n && !done) begin
         sz = q.size(); hk = (sz > 0) && (oidx != 0);
         chk("R1 empty", int'(st_empty), int'(sz == 0));
         chk("R1 full", int'(st_full), int'(sz == DEPTH));
         chk("R7 near", int'(st_near), int'(cfg_near_thr != 0 && sz >= int'(cfg_near_thr)));
         chk("R5 next_status", int'(st_next_status), int'(hk && q[0][8]));
         chk("R3 rd_data", int'(rd_data), hk ? int'(q[0][7:0]) : 0);
         chk("R4 in_msg", int'(st_in_msg), cfg_hdlc ? int'(m_in) : 1);
      end
   end

   task automatic tick(); @(posedge clk); #1; endtask
   task automatic ev_s(); ev_start = 1; tick(); ev_start = 0; endtask
   task automatic ev_b(input logic [7:0] d); ev_byte = 1; ev_data = d; tick(); ev_byte = 0; endtask
   task automatic ev_g(); ev_good = 1; tick(); ev_good = 0; endtask
   task automatic ev_a(); ev_abort = 1; tick(); ev_abort = 0; endtask
   task automatic ev_e(); ev_error = 1; tick(); ev_error = 0; endtask
   task automatic rd1(); rd_en = 1; tick(); rd_en = 0; endtask
   task automatic drain();
      for (int k = 0; k < 2 * DEPTH && !st_empty; k++) rd1();
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1; n_chk++; n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      #1;
      chk("R1 reset empty", int'(st_empty), 1);
      chk("R1 reset full", int'(st_full), 0);
      chk("R4 reset in_msg", int'(st_in_msg), 0);
      chk("R10 reset rd_data", int'(rd_data), 0);
      tick();

      // good frame of three bytes
      ev_s();
      chk("R2 open slot hidden", int'(st_next_status), 0);
      chk("R2 open slot not empty", int'(st_empty), 0);
      rd1();
      chk("R2 read of open slot ignored", int'(st_empty), 0);
      ev_b(8'hA1); ev_b(8'hA2); ev_b(8'hA3); ev_g();
      chk("R3 good status", int'(rd_data), 8'h03);
      chk("R5 status at head", int'(st_next_status), 1);
      rd1();
      chk("R3 first data", int'(rd_data), 8'hA1);
      drain();
      rd1();
      chk("R10 read when empty", int'(rd_data), 0);

      // abort with no data frees the slot; abort and error with data
      ev_s(); ev_a();
      chk("R6 slot released", int'(st_empty), 1);
      ev_s(); ev_b(8'h11); ev_b(8'h22); ev_a();
      chk("R3 abort status", int'(rd_data), 8'h42);
      drain();
      ev_s(); ev_b(8'h33); ev_e();
      chk("R3 error status", int'(rd_data), 8'h81);
      // simultaneous read and write
      ev_s(); rd_en = 1; ev_byte = 1; ev_data = 8'h55; tick(); rd_en = 0; ev_byte = 0;
      ev_g(); drain();

      // near-full partial at threshold 10
      cfg_near_thr = 6'd10;
      ev_s();
      for (int i = 0; i < 15; i++) ev_b(8'(i + 1));
      chk("R7 near set", int'(st_near), 1);
      chk("R8 partial status", int'(rd_data), 8'hC9);
      ev_g();
      for (int i = 0; i < 10; i++) rd1();
      chk("R8 continuation status", int'(rd_data), 8'h06);
      drain();
      chk("R7 near cleared", int'(st_near), 0);
      cfg_near_thr = 6'd0;

      // overflow and a frame opened while full
      ev_s();
      for (int i = 0; i < 70; i++) ev_b(8'(i));
      chk("R9 full", int'(st_full), 1);
      chk("R9 overflow status", int'(rd_data), 8'hC0);
      ev_g();
      ev_s();
      chk("R11 in_msg while full", int'(st_in_msg), 1);
      ev_b(8'h77); ev_g();
      chk("R11 still full", int'(st_full), 1);
      drain();

      // unformatted mode
      cfg_hdlc = 0;
      ev_b(8'h5A); ev_s(); ev_b(8'hA5); ev_g();
      chk("R4 unformatted in_msg", int'(st_in_msg), 1);
      chk("R4 unformatted data", int'(rd_data), 8'h5A);
      chk("R4 data tag", int'(st_next_status), 0);
      drain();
      chk("R4 events ignored", int'(st_empty), 1);
      cfg_hdlc = 1;

      // random traffic, model compared every cycle
      begin
         bit open = 0;
         for (int n = 0; n < 6000; n++) begin
            int r = int'($urandom_range(0, 99));
            if (n % 1500 == 0 && !open) cfg_near_thr = 6'($urandom_range(0, 63));
            rd_en = ($urandom_range(0, 99) < 35);
            if (!open) begin
               if (r < 30) begin ev_start = 1; open = 1; end
            end else if (r < 80) begin
               ev_byte = 1; ev_data = 8'($urandom);
            end else if (r < 87) begin ev_good = 1; open = 0; end
            else if (r < 93) begin ev_abort = 1; open = 0; end
            else if (r < 97) begin ev_error = 1; open = 0; end
            tick();
            {ev_start, ev_byte, ev_good, ev_abort, ev_error, rd_en} = '0;
         end
         if (open) ev_g();
      end
      drain();
      chk("R10 drained", int'(st_empty), 1);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule